// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-on reset to an idle, ready-to-use state without software involvement. A single start pulse launches a fixed program. The device reset is released with clock enable held low, and clock enable is then raised. The four mode registers are loaded from configuration inputs in a fixed order. The delay-locked loop reset is optionally cleared by rewriting mode register 0, and a long ZQ calibration is issued last. Each step is followed by a programmed wait.

The outputs drive a command-injection port in front of the memory controller. They are three control levels (device reset, clock enable, on-die termination), a one-cycle command strobe with active-high chip-select, write-enable, column-strobe and row-strobe bits, a row/column address and a bank address. Wait lengths are given in clock cycles. A right-shift parameter divides them all so that short runs remain possible. A done flag rises after the last wait and stays high until the next start.

Top module: `ddr3_init_seq`

## Requirements
- R1: After reset and before any start, mem_rst_no, cke_o, odt_o, done_o and cmd_valid_o are all 0, and addr_o and ba_o are 0.
- R2: On the first cycle after a start is accepted, mem_rst_no and odt_o are 1, cke_o is 0, and addr_o and ba_o are 0. This state lasts the reset wait.
- R3: When the reset wait ends, cke_o rises. The first command strobe follows one clock-enable wait later, and cke_o, odt_o and mem_rst_no are all 1 whenever cmd_valid_o is high.
- R4: Mode-register-set commands (ras, cas, we and cs all 1) go out in bank order 2, 3, 1, 0. addr_o carries the matching mode input, and successive strobes are CMD_GAP cycles apart.
- R5: If bit 8 of mr0_i is 1, a second mode-register-set to bank 0 follows the first one by the DLL wait, with addr_o equal to mr0_i with bit 8 cleared. If bit 8 is 0, no second write is issued.
- R6: One settle wait after the last bank-0 write, a ZQ calibration command goes out with we and cs 1, ras and cas 0, addr_o equal to 0x400 (bit 10 set) and ba_o equal to 0.
- R7: done_o rises one ZQ wait after the ZQ strobe. It then holds 1, with all three control levels at 1, until the next start.
- R8: A start pulse that arrives while the sequence is running has no effect on the timing or content of any output.
- R9: A start while done_o is 1 restarts the sequence: done_o falls and cke_o returns to 0 on the next cycle.
- R10: Each wait in cycles is its nominal count (50000, 10000, 100, 600, 600) shifted right by WAIT_SHIFT, with a floor of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the sequence (accepted when idle or done) |
| mr0_i | input | 16 | Mode register 0 value |
| mr1_i | input | 16 | Mode register 1 value |
| mr2_i | input | 16 | Mode register 2 value |
| mr3_i | input | 16 | Mode register 3 value |
| done_o | output | 1 | Sequence complete |
| mem_rst_no | output | 1 | Device reset, active low |
| cke_o | output | 1 | Clock enable level |
| odt_o | output | 1 | On-die termination level |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_cs_o | output | 1 | Chip select asserted |
| cmd_we_o | output | 1 | Write enable asserted |
| cmd_cas_o | output | 1 | Column strobe asserted |
| cmd_ras_o | output | 1 | Row strobe asserted |
| addr_o | output | ADDR_W | Command address |
| ba_o | output | BA_W | Command bank address |

## Verification
The assertions take for granted that the mode inputs are held steady while a sequence runs. The bank-0 decision and the address values are read live from those inputs, so a change mid-sequence would alter the command stream. The bench changes the mode values only while the block is idle or done. The bench pulses start_i on purpose during the reset wait and between mode-register writes, which keeps the restart assertions meaningful without breaking that assumption.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_CKE, ST_MR2, ST_MR3, ST_MR1, ST_MR0, ST_MR0B, ST_ZQ, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_bits_t;

  localparam int DLL_RST_BIT = 8;
  localparam int ZQ_LONG_BIT = 10;

  function automatic int scale_wait(input int units, input int shift);
    int v;
    v = units >>> shift;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr3_init_step.sv
module ddr3_init_step
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3,
  parameter int CNT_W  = 16,
  parameter int W_RST  = 1,
  parameter int W_CKE  = 1,
  parameter int W_GAP  = 1,
  parameter int W_DLL  = 1,
  parameter int W_MRD  = 1,
  parameter int W_ZQ   = 1
) (
  input  seq_state_e        state_i,
  input  logic [15:0]       mr0_i,
  input  logic [15:0]       mr1_i,
  input  logic [15:0]       mr2_i,
  input  logic [15:0]       mr3_i,
  output logic              cmd_o,
  output cmd_bits_t         bits_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              rst_n_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic [CNT_W-1:0]  wait_o
);

  localparam cmd_bits_t MRS_BITS = '{ras: 1'b1, cas: 1'b1, we: 1'b1, cs: 1'b1};
  localparam cmd_bits_t ZQ_BITS  = '{ras: 1'b0, cas: 1'b0, we: 1'b1, cs: 1'b1};

  logic dll_rst;
  assign dll_rst = mr0_i[DLL_RST_BIT];

  function automatic logic [CNT_W-1:0] wlen(input int w);
    return CNT_W'(w - 1);
  endfunction

  always_comb begin
    cmd_o   = 1'b0;
    bits_o  = '0;
    addr_o  = '0;
    ba_o    = '0;
    rst_n_o = 1'b1;
    cke_o   = 1'b1;
    odt_o   = 1'b1;
    wait_o  = '0;
    unique case (state_i)
      ST_IDLE: begin rst_n_o = 1'b0; cke_o = 1'b0; odt_o = 1'b0; end
      ST_RST:  begin cke_o = 1'b0; wait_o = wlen(W_RST); end
      ST_CKE:  wait_o = wlen(W_CKE);
      ST_MR2:  begin cmd_o = 1'b1; bits_o = MRS_BITS; addr_o = ADDR_W'(mr2_i);
                     ba_o = BA_W'(2); wait_o = wlen(W_GAP); end
      ST_MR3:  begin cmd_o = 1'b1; bits_o = MRS_BITS; addr_o = ADDR_W'(mr3_i);
                     ba_o = BA_W'(3); wait_o = wlen(W_GAP); end
      ST_MR1:  begin cmd_o = 1'b1; bits_o = MRS_BITS; addr_o = ADDR_W'(mr1_i);
                     ba_o = BA_W'(1); wait_o = wlen(W_GAP); end
      ST_MR0:  begin cmd_o = 1'b1; bits_o = MRS_BITS; addr_o = ADDR_W'(mr0_i);
                     wait_o = dll_rst ? wlen(W_DLL) : wlen(W_MRD); end
      ST_MR0B: begin cmd_o = 1'b1; bits_o = MRS_BITS;
                     addr_o = ADDR_W'(mr0_i & ~(16'(1) << DLL_RST_BIT));
                     wait_o = wlen(W_MRD); end
      ST_ZQ:   begin cmd_o = 1'b1; bits_o = ZQ_BITS;
                     addr_o = ADDR_W'(1) << ZQ_LONG_BIT; wait_o = wlen(W_ZQ); end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BA_W       = 3,
  parameter int WAIT_SHIFT = 0,
  parameter int CMD_GAP    = 4,
  parameter int T_RST      = 50000,
  parameter int T_CKE      = 10000,
  parameter int T_DLL      = 100,
  parameter int T_MRD      = 600,
  parameter int T_ZQ       = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       mr0_i,
  input  logic [15:0]       mr1_i,
  input  logic [15:0]       mr2_i,
  input  logic [15:0]       mr3_i,
  output logic              done_o,
  output logic              mem_rst_no,
  output logic              cke_o,
  output logic              odt_o,
  output logic              cmd_valid_o,
  output logic              cmd_cs_o,
  output logic              cmd_we_o,
  output logic              cmd_cas_o,
  output logic              cmd_ras_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  localparam int W_RST = scale_wait(T_RST, WAIT_SHIFT);
  localparam int W_CKE = scale_wait(T_CKE, WAIT_SHIFT);
  localparam int W_DLL = scale_wait(T_DLL, WAIT_SHIFT);
  localparam int W_MRD = scale_wait(T_MRD, WAIT_SHIFT);
  localparam int W_ZQ  = scale_wait(T_ZQ, WAIT_SHIFT);
  localparam int W_GAP = (CMD_GAP < 1) ? 1 : CMD_GAP;
  localparam int W_MAX = max2(max2(max2(W_RST, W_CKE), max2(W_DLL, W_MRD)), max2(W_ZQ, W_GAP));
  localparam int CNT_W = (W_MAX < 2) ? 1 : $clog2(W_MAX);

  seq_state_e state_q, state_d;
  logic       go;
  logic       tmr_zero;

  logic              s_cmd;
  cmd_bits_t         s_bits;
  logic [ADDR_W-1:0] s_addr;
  logic [BA_W-1:0]   s_ba;
  logic              s_rst_n, s_cke, s_odt;
  logic [CNT_W-1:0]  s_wait;

  always_comb begin
    state_d = state_q;
    go      = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin state_d = ST_RST; go = 1'b1; end
      default: if (tmr_zero) begin
        go = 1'b1;
        unique case (state_q)
          ST_RST:  state_d = ST_CKE;
          ST_CKE:  state_d = ST_MR2;
          ST_MR2:  state_d = ST_MR3;
          ST_MR3:  state_d = ST_MR1;
          ST_MR1:  state_d = ST_MR0;
          ST_MR0:  state_d = mr0_i[DLL_RST_BIT] ? ST_MR0B : ST_ZQ;
          ST_MR0B: state_d = ST_ZQ;
          default: state_d = ST_DONE;
        endcase
      end
    endcase
  end

  ddr3_init_step #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .W_RST(W_RST), .W_CKE(W_CKE), .W_GAP(W_GAP),
    .W_DLL(W_DLL), .W_MRD(W_MRD), .W_ZQ(W_ZQ)
  ) step_i (
    .state_i(state_d), .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i),
    .cmd_o(s_cmd), .bits_o(s_bits), .addr_o(s_addr), .ba_o(s_ba),
    .rst_n_o(s_rst_n), .cke_o(s_cke), .odt_o(s_odt), .wait_o(s_wait)
  );

  ddr3_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go), .val_i(s_wait), .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cmd_valid_o <= 1'b0;
      {cmd_ras_o, cmd_cas_o, cmd_we_o, cmd_cs_o} <= '0;
      addr_o      <= '0;
      ba_o        <= '0;
      mem_rst_no  <= 1'b0;
      cke_o       <= 1'b0;
      odt_o       <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmd_valid_o <= go & s_cmd;
      if (go) begin
        {cmd_ras_o, cmd_cas_o, cmd_we_o, cmd_cs_o} <= s_bits;
        addr_o     <= s_addr;
        ba_o       <= s_ba;
        mem_rst_no <= s_rst_n;
        cke_o      <= s_cke;
        odt_o      <= s_odt;
        done_o     <= (state_d == ST_DONE);
      end
    end
  end

  a_r2_reset_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RST) |-> (!cke_o && odt_o && mem_rst_no && addr_o == '0 && ba_o == '0));
  a_r3_cmd_needs_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cke_o && odt_o && mem_rst_no));
  a_r4_mrs_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ras_o) |-> (cmd_cas_o && cmd_we_o && cmd_cs_o));
  a_r6_zq_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ras_o) |->
      (!cmd_cas_o && cmd_we_o && cmd_cs_o && addr_o == (ADDR_W'(1) << ZQ_LONG_BIT) && ba_o == '0));
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && cke_o && odt_o && mem_rst_no));
  a_r7_no_cmd_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);
  a_r9_cke_falls_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(start_i));

endmodule

// File: tb/ddr3_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;

  localparam int SHIFT = 7;
  localparam int GAP   = 4;

  function automatic int sw(input int u);
    int v;
    v = u >>> SHIFT;
    return (v < 1) ? 1 : v;
  endfunction

  localparam int WR = sw(50000);
  localparam int WC = sw(10000);
  localparam int WD = sw(100);
  localparam int WM = sw(600);
  localparam int WZ = sw(600);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] mr0_i = '0, mr1_i = '0, mr2_i = '0, mr3_i = '0;
  logic done_o, mem_rst_no, cke_o, odt_o, cmd_valid_o;
  logic cmd_cs_o, cmd_we_o, cmd_cas_o, cmd_ras_o;
  logic [15:0] addr_o;
  logic [2:0]  ba_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  ddr3_init_seq #(.WAIT_SHIFT(SHIFT), .CMD_GAP(GAP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i),
    .done_o(done_o), .mem_rst_no(mem_rst_no), .cke_o(cke_o), .odt_o(odt_o),
    .cmd_valid_o(cmd_valid_o), .cmd_cs_o(cmd_cs_o), .cmd_we_o(cmd_we_o),
    .cmd_cas_o(cmd_cas_o), .cmd_ras_o(cmd_ras_o), .addr_o(addr_o), .ba_o(ba_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!mem_rst_no && !cke_o && !odt_o, "R1", "levels", {mem_rst_no, cke_o, odt_o}, 0);
    chk(!done_o && !cmd_valid_o, "R1", "done/strobe", {done_o, cmd_valid_o}, 0);
    chk(addr_o == 0 && ba_o == 0, "R1", "addr/ba", {ba_o, addr_o}, 0);
  endtask

  // poke_k >= 0 pulses start again at that cycle of the run (R8)
  task automatic run_seq(input logic [15:0] m0, m1, m2, m3, input int poke_k);
    int ek[6]; int eba[6]; int ea[6]; int eb[6]; string erq[6];
    int n, t, dk, idx;
    bit dll;
    dll = m0[8];
    t = WR + WC;
    ek[0] = t;         eba[0] = 2; ea[0] = m2; eb[0] = 4'hF; erq[0] = "R4";
    ek[1] = t + GAP;   eba[1] = 3; ea[1] = m3; eb[1] = 4'hF; erq[1] = "R4";
    ek[2] = t + 2*GAP; eba[2] = 1; ea[2] = m1; eb[2] = 4'hF; erq[2] = "R4";
    ek[3] = t + 3*GAP; eba[3] = 0; ea[3] = m0; eb[3] = 4'hF; erq[3] = "R4";
    n = 4; t = t + 3*GAP;
    if (dll) begin
      t = t + WD;  // R10: floor of 1 cycle applies here
      ek[n] = t; eba[n] = 0; ea[n] = m0 & 16'hFEFF; eb[n] = 4'hF; erq[n] = "R5"; n++;
    end
    t = t + WM;
    ek[n] = t; eba[n] = 0; ea[n] = 16'h0400; eb[n] = 4'h3; erq[n] = "R6"; n++;
    dk = t + WZ;
    @(negedge clk_i);
    mr0_i = m0; mr1_i = m1; mr2_i = m2; mr3_i = m3;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    idx = 0;
    for (int k = 0; k <= dk; k++) begin
      if (k > 0) @(negedge clk_i);
      if (k == 0) begin
        chk(mem_rst_no && odt_o && !cke_o, "R2", "levels at start", {mem_rst_no, odt_o, cke_o}, 6);
        chk(addr_o == 0 && ba_o == 0, "R2", "addr/ba at start", {ba_o, addr_o}, 0);
        chk(!done_o, "R9", "done after start", done_o, 0);
      end
      if (k == WR - 1) chk(!cke_o, "R3", "cke before raise", cke_o, 0);
      if (k == WR)     chk(cke_o, "R3", "cke raised", cke_o, 1);
      if (cmd_valid_o) begin
        if (idx < n) begin
          chk(k == ek[idx], erq[idx], "strobe cycle", k, ek[idx]);
          chk(ba_o == eba[idx], erq[idx], "bank", ba_o, eba[idx]);
          chk(addr_o == ea[idx], erq[idx], "address", addr_o, ea[idx]);
          chk({cmd_ras_o, cmd_cas_o, cmd_we_o, cmd_cs_o} == eb[idx], erq[idx], "cmd bits",
              {cmd_ras_o, cmd_cas_o, cmd_we_o, cmd_cs_o}, eb[idx]);
        end else begin
          chk(1'b0, "R5", "extra strobe", k, -1);
        end
        idx++;
      end
      if (k == dk - 1) chk(!done_o, "R7", "done early", done_o, 0);
      if (k == dk)     chk(done_o, "R7", "done on time", done_o, 1);
      start_i = (k == poke_k);
    end
    start_i = 1'b0;
    chk(idx == n, (poke_k >= 0) ? "R8" : "R5", "strobe count", idx, n);
    repeat (5) @(negedge clk_i);
    chk(done_o && cke_o && odt_o && mem_rst_no, "R7", "done holds",
        {done_o, cke_o, odt_o, mem_rst_no}, 15);
  endtask

  task automatic t_no_dll();
    run_seq(16'h0420, 16'h0044, 16'h0018, 16'h0000, -1);
  endtask

  task automatic t_dll_restart();
    // restarts from done (R9); MR0 bit 8 set exercises R5 and the R10 floor
    run_seq(16'h0D70, 16'h0006, 16'h0200, 16'h0004, -1);
  endtask

  task automatic t_busy_start();
    run_seq(16'h0120, 16'h0002, 16'h0008, 16'h0001, 40);
    run_seq(16'h0320, 16'h0006, 16'h0200, 16'h0000, WR + WC + 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_no_dll();
    t_dll_restart();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule